// File: doc/BRIEF.md
# Dual-Threshold Elastic Stream FIFO

This block is a single-clock elastic buffer placed between a bursty sample producer and a packet builder. Words enter through a valid/ready input port and leave through a valid/ready output port in arrival order. Three programmable occupancy levels control its behaviour. The upper level raises a throttle request to the producer. A lower release level clears that request again, so the request has hysteresis. A protective shed level makes the buffer discard further input words on purpose rather than overrun its storage.

Loss and stress are always visible at the ports. Each discarded word increments a shed counter. Each unbroken run of discards increments an overflow-episode counter. A peak register holds the highest occupancy seen in the current session. A session-clear pulse starts a new measurement window without touching the stored words.

The input ready is held low only during reset and is high at all other times. Flow control toward the producer goes through the throttle output. Shedding is the last line of defence.

Top module: `elastic_stream_fifo`

## Requirements
- R1: After reset the output port shows no valid word, throttle is low, the shed counter, the episode counter and the peak register read zero, and input ready is high from the first clock after reset is released.
- R2: Words leave in the order they were accepted. The output valid is high exactly while at least one word is stored.
- R3: Stored occupancy never exceeds DEPTH, provided the shed level is at most DEPTH. After any amount of shedding, draining returns exactly the accepted words.
- R4: An input word offered when occupancy minus this cycle's pop is at least the shed level is discarded. Discarding leaves the stored contents unchanged and increments the shed counter by one.
- R5: When a word is offered and a word is popped in the same cycle while occupancy equals the shed level, the offered word is stored.
- R6: Throttle is high in every cycle in which occupancy is at or above the upper level.
- R7: Once throttle is high, it stays high until occupancy falls below the release level. When occupancy rises from below, throttle stays low until occupancy reaches the upper level.
- R8: The peak register equals the largest occupancy reached since the last session clear or reset, and it updates on the same edge as the occupancy.
- R9: A session-clear pulse sets the shed and episode counters to zero and loads the peak register with the occupancy after that edge. It neither flushes nor reorders the stored words.
- R10: The episode counter increments once for each run of discards in consecutive cycles. A cycle without a discard ends the run.
- R11: The shed and episode counters stop at their all-ones value and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_clr | input | 1 | Session-clear pulse for the telemetry |
| lvl_low | input | OCC_W | Throttle release level |
| lvl_high | input | OCC_W | Throttle assert level |
| lvl_drop | input | OCC_W | Shed level |
| s_valid | input | 1 | Input word offered |
| s_ready | output | 1 | Input ready (high outside reset) |
| s_data | input | DATA_W | Input word |
| m_valid | output | 1 | Output word available |
| m_ready | input | 1 | Consumer takes the output word |
| m_data | output | DATA_W | Oldest stored word |
| throttle | output | 1 | Slow-down request to the producer |
| shed_count | output | CNT_W | Saturating count of discarded words |
| ovf_events | output | CNT_W | Saturating count of discard runs |
| peak_occ | output | OCC_W | Peak occupancy in the current session |

## Verification
The hardest case to reach from the ports is a push and a pop landing in the same cycle while the buffer sits exactly at the shed level. In that cycle a push would normally be discarded, and only the concurrent pop lets it in. The stimulus first fills the buffer to the shed level and confirms with extra pushes that words are being discarded. It then asserts input valid and output ready together for one cycle. It checks that the shed count does not move and that the new word comes out last during the drain. Counter saturation is reached with a narrow counter width and many alternating idle and discard cycles, which also separates the word count from the run count.

// File: rtl/esf_pkg.sv
// Shared definitions for the elastic stream FIFO.
// Assumes nothing beyond a single clock domain.
package esf_pkg;

    // Hysteresis state of the throttle request.
    typedef enum logic {
        THR_OPEN = 1'b0,
        THR_HELD = 1'b1
    } thr_state_e;

endpackage

// File: rtl/esf_store.sv
// Circular word storage with separate write and read pointers.
// Assumes the caller never writes when full or reads when empty;
// occupancy is tracked outside this module.
module esf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // Write accepted words into the array.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance both pointers with wrap at DEPTH-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    // Present the oldest word.
    always_comb begin
        rd_data = mem[rd_ptr];
    end

endmodule

// File: rtl/esf_level.sv
// Occupancy tracking, accept/shed decision and throttle hysteresis.
// Assumes lvl_low <= lvl_high < lvl_drop <= DEPTH; the ordering is not checked.
module esf_level #(
    parameter int DEPTH = 16,
    parameter int OCC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_try,
    input  logic             pop_req,
    input  logic [OCC_W-1:0] lvl_low,
    input  logic [OCC_W-1:0] lvl_high,
    input  logic [OCC_W-1:0] lvl_drop,
    output logic             push_acc,
    output logic             push_shed,
    output logic             pop_acc,
    output logic             not_empty,
    output logic [OCC_W-1:0] occ,
    output logic [OCC_W-1:0] occ_nxt,
    output logic             throttle
);
    import esf_pkg::*;

    logic [OCC_W-1:0] occ_after_pop;
    thr_state_e       thr_q;

    // Decide pop, accept or shed, and next occupancy.
    always_comb begin
        not_empty     = (occ != '0);
        pop_acc       = pop_req && not_empty;
        occ_after_pop = occ - OCC_W'(pop_acc);
        push_acc      = push_try && (occ_after_pop < lvl_drop);
        push_shed     = push_try && !push_acc;
        occ_nxt       = occ_after_pop + OCC_W'(push_acc);
    end

    // Throttle: set at the upper level, held down to the release level.
    always_comb begin
        throttle = (occ >= lvl_high) || ((thr_q == THR_HELD) && (occ >= lvl_low));
    end

    // Register occupancy and the hysteresis state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ   <= '0;
            thr_q <= THR_OPEN;
        end else begin
            occ   <= occ_nxt;
            thr_q <= throttle ? THR_HELD : THR_OPEN;
        end
    end

endmodule

// File: rtl/esf_sat_counter.sv
// Saturating up-counter with a synchronous clear.
// A clear in the same cycle as an increment leaves the value at one.
module esf_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    // Count up, stop at all-ones, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= W'(inc);
        end else if (inc && (value != {W{1'b1}})) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/esf_telemetry.sv
// Session telemetry: shed word count, shed run count and peak occupancy.
// Assumes occ_nxt is the occupancy that the next edge will register.
module esf_telemetry #(
    parameter int OCC_W = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sess_clr,
    input  logic             push_shed,
    input  logic [OCC_W-1:0] occ_nxt,
    output logic [CNT_W-1:0] shed_count,
    output logic [CNT_W-1:0] ovf_events,
    output logic [OCC_W-1:0] peak_occ
);
    logic shed_prev_q;
    logic run_start;

    // A run starts on a discard that follows a cycle without one.
    always_comb begin
        run_start = push_shed && !shed_prev_q;
    end

    // Remember whether the last cycle discarded a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shed_prev_q <= 1'b0;
        end else begin
            shed_prev_q <= push_shed;
        end
    end

    esf_sat_counter #(.W(CNT_W)) u_shed_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sess_clr),
        .inc   (push_shed),
        .value (shed_count)
    );

    esf_sat_counter #(.W(CNT_W)) u_run_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sess_clr),
        .inc   (run_start),
        .value (ovf_events)
    );

    // Track the session maximum of occupancy, reloaded on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_occ <= '0;
        end else if (sess_clr || (occ_nxt > peak_occ)) begin
            peak_occ <= occ_nxt;
        end
    end

endmodule

// File: rtl/elastic_stream_fifo.sv
// Elastic stream FIFO with throttle and protective shedding.
// Assumes one clock and levels ordered lvl_low <= lvl_high < lvl_drop <= DEPTH.
// Input ready is high whenever the block is out of reset; overload is
// signalled by throttle and absorbed by counted discards.
module elastic_stream_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_clr,
    input  logic [OCC_W-1:0]  lvl_low,
    input  logic [OCC_W-1:0]  lvl_high,
    input  logic [OCC_W-1:0]  lvl_drop,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              throttle,
    output logic [CNT_W-1:0]  shed_count,
    output logic [CNT_W-1:0]  ovf_events,
    output logic [OCC_W-1:0]  peak_occ
);
    logic             push_try;
    logic             push_acc;
    logic             push_shed;
    logic             pop_acc;
    logic [OCC_W-1:0] occ;
    logic [OCC_W-1:0] occ_nxt;

    // Input ready comes up one clock after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ready <= 1'b0;
        end else begin
            s_ready <= 1'b1;
        end
    end

    // An input handshake attempt.
    always_comb begin
        push_try = s_valid && s_ready;
    end

    esf_level #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_try  (push_try),
        .pop_req   (m_ready),
        .lvl_low   (lvl_low),
        .lvl_high  (lvl_high),
        .lvl_drop  (lvl_drop),
        .push_acc  (push_acc),
        .push_shed (push_shed),
        .pop_acc   (pop_acc),
        .not_empty (m_valid),
        .occ       (occ),
        .occ_nxt   (occ_nxt),
        .throttle  (throttle)
    );

    esf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_acc),
        .wr_data (s_data),
        .rd_en   (pop_acc),
        .rd_data (m_data)
    );

    esf_telemetry #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_telem (
        .clk        (clk),
        .rst_n      (rst_n),
        .sess_clr   (sess_clr),
        .push_shed  (push_shed),
        .occ_nxt    (occ_nxt),
        .shed_count (shed_count),
        .ovf_events (ovf_events),
        .peak_occ   (peak_occ)
    );

endmodule

// File: rtl/esf_checker.sv
// Temporal checks for elastic_stream_fifo, attached by bind.
module esf_checker #(
    parameter int DEPTH = 16,
    parameter int OCC_W = 5,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sess_clr,
    input logic             push_try,
    input logic             push_acc,
    input logic             push_shed,
    input logic             pop_acc,
    input logic [OCC_W-1:0] occ,
    input logic [OCC_W-1:0] lvl_low,
    input logic [OCC_W-1:0] lvl_high,
    input logic [OCC_W-1:0] lvl_drop,
    input logic             throttle,
    input logic [CNT_W-1:0] shed_count,
    input logic [OCC_W-1:0] peak_occ
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [OCC_W-1:0] DMAX = OCC_W'(DEPTH);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_drop <= DMAX) |-> (occ <= DMAX));

    p_shed_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_shed && !sess_clr && shed_count != CMAX)
        |=> (shed_count - $past(shed_count) == CNT_W'(1)));

    p_shed_keeps_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_shed |=> (occ == $past(occ) - OCC_W'($past(pop_acc))));

    p_simul_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_try && pop_acc && occ == lvl_drop) |-> push_acc);

    p_throttle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ >= lvl_high) |-> throttle);

    p_throttle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        throttle |=> (throttle || occ < lvl_low));

    p_peak_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        peak_occ >= occ);

    p_shed_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_shed && !sess_clr && shed_count == CMAX) |=> (shed_count == CMAX));

endmodule

bind elastic_stream_fifo esf_checker #(
    .DEPTH (DEPTH),
    .OCC_W (OCC_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sess_clr   (sess_clr),
    .push_try   (push_try),
    .push_acc   (push_acc),
    .push_shed  (push_shed),
    .pop_acc    (pop_acc),
    .occ        (occ),
    .lvl_low    (lvl_low),
    .lvl_high   (lvl_high),
    .lvl_drop   (lvl_drop),
    .throttle   (throttle),
    .shed_count (shed_count),
    .peak_occ   (peak_occ)
);

// File: tb/sim_elastic_stream_fifo.sv
// Directed bench: DEPTH 8, release 2, upper 5, shed 7, 4-bit counters.
module sim_elastic_stream_fifo;
    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int CW    = 4;
    localparam int OW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sess_clr;
    logic [OW-1:0] lvl_low, lvl_high, lvl_drop;
    logic          s_valid, s_ready, m_valid, m_ready, throttle;
    logic [DW-1:0] s_data, m_data;
    logic [CW-1:0] shed_count, ovf_events;
    logic [OW-1:0] peak_occ;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    elastic_stream_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .sess_clr(sess_clr),
        .lvl_low(lvl_low), .lvl_high(lvl_high), .lvl_drop(lvl_drop),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .throttle(throttle), .shed_count(shed_count),
        .ovf_events(ovf_events), .peak_occ(peak_occ)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push1(input int d);
        s_valid = 1'b1;
        s_data  = DW'(d);
        tick();
        s_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input int d);
        chk(req, "m_valid before pop", int'(m_valid), 1);
        chk(req, "m_data order", int'(m_data), d);
        m_ready = 1'b1;
        tick();
        m_ready = 1'b0;
    endtask

    task automatic pulse_clear();
        sess_clr = 1'b1;
        tick();
        sess_clr = 1'b0;
    endtask

    // R1: state right after reset release.
    task automatic t_reset();
        chk("R1", "m_valid", int'(m_valid), 0);
        chk("R1", "throttle", int'(throttle), 0);
        chk("R1", "shed_count", int'(shed_count), 0);
        chk("R1", "ovf_events", int'(ovf_events), 0);
        chk("R1", "peak_occ", int'(peak_occ), 0);
        chk("R1", "s_ready", int'(s_ready), 1);
    endtask

    // R6 R8 R4 R10: fill to the shed level, then overrun.
    task automatic t_fill_and_shed();
        for (int i = 0; i < 7; i++) begin
            push1(100 + i);
            chk("R6", "throttle while filling", int'(throttle), (i + 1 >= 5) ? 1 : 0);
            chk("R8", "peak while filling", int'(peak_occ), i + 1);
        end
        for (int i = 0; i < 3; i++) begin
            push1(300 + i);
            chk("R4", "shed count per discard", int'(shed_count), i + 1);
        end
        chk("R10", "one run counted", int'(ovf_events), 1);
        chk("R8", "peak after shed", int'(peak_occ), 7);
        chk("R4", "head unchanged", int'(m_data), 100);
    endtask

    // R5 R2 R7: push and pop together at the shed level, then drain.
    task automatic t_simul_and_drain();
        chk("R5", "head before", int'(m_data), 100);
        s_valid = 1'b1;
        s_data  = DW'(200);
        m_ready = 1'b1;
        tick();
        s_valid = 1'b0;
        m_ready = 1'b0;
        chk("R5", "no shed on simultaneous push", int'(shed_count), 3);
        for (int k = 1; k <= 7; k++) begin
            pop_expect("R2", (k < 7) ? (100 + k) : 200);
            chk("R7", "throttle while draining", int'(throttle), (7 - k >= 2) ? 1 : 0);
        end
        chk("R2", "empty after drain", int'(m_valid), 0);
    endtask

    // R7: rising from below, then falling through the band.
    task automatic t_hysteresis();
        for (int i = 0; i < 4; i++) begin
            push1(400 + i);
            chk("R7", "low while rising", int'(throttle), 0);
        end
        push1(404);
        chk("R6", "set at upper level", int'(throttle), 1);
        for (int k = 0; k < 4; k++) begin
            pop_expect("R2", 400 + k);
            chk("R7", "held inside band", int'(throttle), (4 - k >= 2) ? 1 : 0);
        end
        pop_expect("R2", 404);
    endtask

    // R10: discards separated by an idle cycle form separate runs.
    task automatic t_runs();
        for (int i = 0; i < 7; i++) push1(500 + i);
        push1(900);
        push1(901);
        chk("R4", "shed after two more", int'(shed_count), 5);
        chk("R10", "consecutive discards one run", int'(ovf_events), 2);
        tick();
        push1(902);
        chk("R4", "shed after gap", int'(shed_count), 6);
        chk("R10", "gap starts new run", int'(ovf_events), 3);
    endtask

    // R9: session clear keeps data, resets telemetry.
    task automatic t_clear();
        pulse_clear();
        chk("R9", "shed cleared", int'(shed_count), 0);
        chk("R9", "runs cleared", int'(ovf_events), 0);
        chk("R9", "peak reloaded", int'(peak_occ), 7);
        for (int k = 0; k < 3; k++) pop_expect("R9", 500 + k);
        chk("R8", "peak holds max", int'(peak_occ), 7);
        pulse_clear();
        chk("R9", "peak reloaded to 4", int'(peak_occ), 4);
        for (int k = 3; k < 7; k++) pop_expect("R9", 500 + k);
        chk("R9", "empty after drain", int'(m_valid), 0);
        pulse_clear();
        chk("R9", "peak reloaded to 0", int'(peak_occ), 0);
    endtask

    // R11 R3: counter saturation and exact contents after heavy shedding.
    task automatic t_saturate();
        for (int i = 0; i < 7; i++) push1(600 + i);
        s_valid = 1'b1;
        s_data  = DW'(999);
        for (int i = 0; i < 20; i++) tick();
        s_valid = 1'b0;
        chk("R11", "shed saturates", int'(shed_count), 15);
        chk("R10", "long burst one run", int'(ovf_events), 1);
        for (int i = 0; i < 16; i++) begin
            tick();
            push1(998);
        end
        chk("R11", "runs saturate", int'(ovf_events), 15);
        chk("R11", "shed stays saturated", int'(shed_count), 15);
        for (int k = 0; k < 7; k++) pop_expect("R3", 600 + k);
        chk("R3", "exactly the accepted words", int'(m_valid), 0);
    endtask

    initial begin
        rst_n    = 1'b0;
        sess_clr = 1'b0;
        s_valid  = 1'b0;
        m_ready  = 1'b0;
        s_data   = '0;
        lvl_low  = OW'(2);
        lvl_high = OW'(5);
        lvl_drop = OW'(7);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_fill_and_shed();
        t_simul_and_drain();
        t_hysteresis();
        t_runs();
        t_clear();
        t_saturate();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule